// File: doc/BRIEF.md
# Serial Controller Register and Flag Unit

This block is the processor-facing side of an asynchronous serial port with an 8-bit bus. It holds a baud register, two control registers, a status register and a data port. It keeps the transmit-empty, transmit-complete, receive-full and overrun flags. Characters are modelled whole rather than bit by bit. A byte launched for transmit appears on an output strobe one character time later. A received byte is taken from an input strobe and moved into the data register at the next character-time boundary.

Two small state machines do the timing. The transmit machine has two states. In `TX_IDLE` it waits for a pending byte with transmit enabled; that is the *launch* transition to `TX_SEND`. In `TX_SEND` it counts one character time; that is the *done* transition back to `TX_IDLE`. The receive machine also has two states. In `RX_OFF` it waits for receive enable; that is the *arm* transition to `RX_WAIT`. In `RX_WAIT` it ticks once per character time and delivers any waiting byte at each tick. Dropping the enable is the *disarm* transition back to `RX_OFF`. The character time comes from the baud and frame-length fields. Flags are cleared by reading the status register and then the data register. An interrupt request combines the flags with the enables.

Top module: `sci_regs`

## Requirements
- R1: After reset, the baud, control-1 and control-2 registers read 0, and status reads 0xC0. Status bit positions are: bit7 transmit-empty, bit6 transmit-complete, bit5 receive-full, bit4 idle, bit3 overrun, bit2 noise, bit1 framing. If `boot_mode` is high during reset, control-2 instead resets to 0x12.
- R2: Addresses are 0 baud, 1 control-1, 2 control-2, 3 status, 4 data. `bus_rdata` always shows the addressed register. Addresses 5 to 7 read 0 and have no side effect.
- R3: A status read (strobed) takes a snapshot of receive-full and overrun. A later data read clears exactly the snapshotted flags and returns the received byte. A data read with no prior status read leaves receive-full set.
- R4: A byte delivered while receive-full is set sets overrun. Receive-full stays set, and the pending clear snapshot is dropped, including when the delivery shares a cycle with the data read.
- R5: Writes to the status address change nothing.
- R6: A data write while transmit-empty is clear is ignored. Otherwise the byte becomes pending.
- R7: With transmit enable (control-2 bit3) set and a byte pending, transmit-empty and transmit-complete clear on the edge after the write. One character time later both flags set again, and `tx_valid` pulses with the byte. With enable clear, the byte waits and both flags stay set.
- R8: The character time in clocks is P × OVERSAMPLE × 2^S × F. P is 1, 3, 4 or 13 for baud bits [5:4] = 0 to 3. S is baud bits [2:0]. F is 11 when control-1 bit4 is set and 10 otherwise.
- R9: Reception runs only while control-2 bit2 is set. A byte strobed in is moved to the data register at the next tick. Ticks fall every character time, starting one character time after the first edge that sees the enable. Bytes strobed with the enable clear are lost.
- R10: `irq` is high when any of these holds: control-2 bit7 with transmit-empty, bit6 with transmit-complete, bit5 with receive-full or overrun, or bit4 with idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_mode | input | 1 | Selects bootstrap reset value for control-2 |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmitted byte strobe |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Interrupt request |

## Verification
The risky coincidence is a receive tick that delivers a new byte on the same edge as the data read that should finish a clear sequence. The bench computes the tick edges from the moment the enable is written. It places the data read exactly on the second tick, after a status read taken while only receive-full was set. The judged result is that receive-full stays set, overrun sets, and the following status read shows both. Only a fresh status-then-data pair then clears them.

// File: rtl/sci_pkg.sv
package sci_pkg;
    typedef enum logic {TX_IDLE, TX_SEND} tx_state_t;
    typedef enum logic {RX_OFF, RX_WAIT} rx_state_t;

    localparam logic [2:0] A_BAUD = 3'd0;
    localparam logic [2:0] A_CTL1 = 3'd1;
    localparam logic [2:0] A_CTL2 = 3'd2;
    localparam logic [2:0] A_STAT = 3'd3;
    localparam logic [2:0] A_DATA = 3'd4;

    localparam int C2_TXE_IE = 7;
    localparam int C2_TXC_IE = 6;
    localparam int C2_RX_IE  = 5;
    localparam int C2_IDL_IE = 4;
    localparam int C2_TX_EN  = 3;
    localparam int C2_RX_EN  = 2;
    localparam int C1_LONG   = 4;

    localparam logic [7:0] BOOT_CTL2 = 8'h12;
endpackage

// File: rtl/sci_char_timer.sv
module sci_char_timer #(
    parameter int OVERSAMPLE = 16,
    parameter int CNT_W      = 19
) (
    input  logic [7:0]       baud,
    input  logic             long_frame,
    output logic [CNT_W-1:0] char_time
);
    logic [3:0] pre;
    logic [3:0] bits;

    always_comb begin
        unique case (baud[5:4])
            2'd0:    pre = 4'd1;
            2'd1:    pre = 4'd3;
            2'd2:    pre = 4'd4;
            default: pre = 4'd13;
        endcase
        bits = long_frame ? 4'd11 : 4'd10;
        char_time = (CNT_W'(pre) * CNT_W'(OVERSAMPLE) * CNT_W'(bits)) << baud[2:0];
    end
endmodule

// File: rtl/sci_tx_fsm.sv
module sci_tx_fsm
    import sci_pkg::*;
#(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             pending,
    input  logic [CNT_W-1:0] char_time,
    output logic             launch,
    output logic             done
);
    tx_state_t        state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                TX_IDLE: if (launch) begin
                    state <= TX_SEND;
                    cnt   <= char_time - CNT_W'(1);
                end
                TX_SEND: if (cnt == '0) state <= TX_IDLE;
                         else cnt <= cnt - CNT_W'(1);
            endcase
        end
    end

    always_comb begin
        launch = (state == TX_IDLE) && tx_en && pending;
        done   = (state == TX_SEND) && (cnt == '0);
    end
endmodule

// File: rtl/sci_rx_fsm.sv
module sci_rx_fsm
    import sci_pkg::*;
#(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic [CNT_W-1:0] char_time,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             deliver,
    output logic [7:0]       line_byte
);
    rx_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic             line_full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_OFF;
            cnt   <= '0;
        end else begin
            unique case (state)
                RX_OFF: if (rx_en) begin
                    state <= RX_WAIT;
                    cnt   <= char_time - CNT_W'(1);
                end
                RX_WAIT: if (!rx_en) state <= RX_OFF;
                         else if (cnt == '0) cnt <= char_time - CNT_W'(1);
                         else cnt <= cnt - CNT_W'(1);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_full <= 1'b0;
            line_byte <= '0;
        end else if (!rx_en) begin
            line_full <= 1'b0;
        end else if (rx_valid) begin
            line_full <= 1'b1;
            line_byte <= rx_byte;
        end else if (deliver) begin
            line_full <= 1'b0;
        end
    end

    always_comb begin
        deliver = (state == RX_WAIT) && rx_en && (cnt == '0) && line_full;
    end
endmodule

// File: rtl/sci_regs.sv
module sci_regs
    import sci_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    localparam int MAX_CT    = 13 * OVERSAMPLE * 128 * 11,
    localparam int CNT_W     = $clog2(MAX_CT + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boot_mode,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       irq
);
    logic [7:0] baud_q, ctl1_q, ctl2_q;
    logic       tdre, tc, rdrf, ovr;
    logic [1:0] snap;
    logic [7:0] rx_data;
    logic [7:0] tx_hold, tx_shift;
    logic       pending;
    logic [7:0] status;
    logic [CNT_W-1:0] char_time;
    logic       launch, done, deliver;
    logic [7:0] line_byte;
    logic       wr_baud, wr_ctl1, wr_ctl2, wr_data, rd_stat, rd_data;

    always_comb begin
        wr_baud = bus_sel &&  bus_wr && (bus_addr == A_BAUD);
        wr_ctl1 = bus_sel &&  bus_wr && (bus_addr == A_CTL1);
        wr_ctl2 = bus_sel &&  bus_wr && (bus_addr == A_CTL2);
        wr_data = bus_sel &&  bus_wr && (bus_addr == A_DATA) && tdre;
        rd_stat = bus_sel && !bus_wr && (bus_addr == A_STAT);
        rd_data = bus_sel && !bus_wr && (bus_addr == A_DATA);
        status  = {tdre, tc, rdrf, 1'b0, ovr, 3'b000};
        unique case (bus_addr)
            A_BAUD:  bus_rdata = baud_q;
            A_CTL1:  bus_rdata = ctl1_q;
            A_CTL2:  bus_rdata = ctl2_q;
            A_STAT:  bus_rdata = status;
            A_DATA:  bus_rdata = rx_data;
            default: bus_rdata = 8'h00;
        endcase
        irq = (ctl2_q[C2_TXE_IE] && tdre) || (ctl2_q[C2_TXC_IE] && tc) ||
              (ctl2_q[C2_RX_IE] && (rdrf || ovr)) || (ctl2_q[C2_IDL_IE] && status[4]);
    end

    sci_char_timer #(.OVERSAMPLE(OVERSAMPLE), .CNT_W(CNT_W)) u_timer (
        .baud(baud_q), .long_frame(ctl1_q[C1_LONG]), .char_time(char_time)
    );

    sci_tx_fsm #(.CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_en(ctl2_q[C2_TX_EN]), .pending(pending),
        .char_time(char_time), .launch(launch), .done(done)
    );

    sci_rx_fsm #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_en(ctl2_q[C2_RX_EN]), .char_time(char_time),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .deliver(deliver), .line_byte(line_byte)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            baud_q <= '0;
            ctl1_q <= '0;
            ctl2_q <= boot_mode ? BOOT_CTL2 : 8'h00;
        end else begin
            if (wr_baud) baud_q <= bus_wdata;
            if (wr_ctl1) ctl1_q <= bus_wdata;
            if (wr_ctl2) ctl2_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdre     <= 1'b1;
            tc       <= 1'b1;
            pending  <= 1'b0;
            tx_hold  <= '0;
            tx_shift <= '0;
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= 1'b0;
            if (launch) begin
                tdre     <= 1'b0;
                tc       <= 1'b0;
                pending  <= 1'b0;
                tx_shift <= tx_hold;
            end
            if (done) begin
                tdre     <= 1'b1;
                tc       <= 1'b1;
                tx_valid <= 1'b1;
                tx_byte  <= tx_shift;
            end
            if (wr_data) begin
                tx_hold <= bus_wdata;
                pending <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdrf    <= 1'b0;
            ovr     <= 1'b0;
            snap    <= '0;
            rx_data <= '0;
        end else if (deliver) begin
            ovr     <= ovr | rdrf;
            rdrf    <= 1'b1;
            rx_data <= line_byte;
            snap    <= '0;
        end else begin
            if (rd_stat) snap <= {rdrf, ovr};
            if (rd_data) begin
                rdrf <= rdrf & ~snap[1];
                ovr  <= ovr & ~snap[0];
            end
        end
    end
endmodule

// File: rtl/sci_regs_chk.sv
module sci_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic       tdre,
    input logic       tc,
    input logic       rdrf,
    input logic       ovr,
    input logic [1:0] snap,
    input logic [7:0] tx_hold,
    input logic       launch,
    input logic       done,
    input logic       deliver,
    input logic       tx_valid,
    input logic [7:0] ctl2_q,
    input logic       irq
);
    logic data_wr, data_rd, stat_wr;
    assign data_wr = bus_sel && bus_wr && (bus_addr == 3'd4);
    assign data_rd = bus_sel && !bus_wr && (bus_addr == 3'd4);
    assign stat_wr = bus_sel && bus_wr && (bus_addr == 3'd3);

    AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !tdre) |=> $stable(tx_hold)); // R6
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver && rdrf) |=> (ovr && rdrf)); // R4
    AST_TX_FLAGS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tdre && tc)); // R7
    AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (!tdre && !tc)); // R7
    AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !launch && !done && !deliver) |=> ($stable(tdre) && $stable(tc) && $stable(rdrf) && $stable(ovr))); // R5
    AST_LONE_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && snap == 2'b00 && !deliver) |=> ($stable(rdrf) && $stable(ovr))); // R3
    AST_IRQ_TX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl2_q[7] && tdre) |-> irq); // R10
endmodule

bind sci_regs sci_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .tdre(tdre), .tc(tc), .rdrf(rdrf), .ovr(ovr), .snap(snap), .tx_hold(tx_hold),
    .launch(launch), .done(done), .deliver(deliver), .tx_valid(tx_valid),
    .ctl2_q(ctl2_q), .irq(irq)
);

// File: tb/sim_sci_regs.sv
`timescale 1ns/1ps
module sim_sci_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_mode = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'd0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sci_regs #(.OVERSAMPLE(1)) u0 (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic access(input bit w, input logic [2:0] a, input logic [7:0] d, output logic [7:0] rd);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1 rd = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wrt(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] x;
        access(1'b1, a, d, x);
    endtask

    task automatic rdt(input logic [2:0] a, output logic [7:0] rd);
        access(1'b0, a, 8'h00, rd);
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] rd);
        bus_addr = a;
        #1 rd = bus_rdata;
    endtask

    task automatic rx_pulse(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        @(posedge clk); @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [7:0] v;
        int c, exp_n;
        @(negedge clk);
        tick(3);
        rst_n = 1'b1;

        // R1 reset state
        peek(3'd3, v); chk("R1 status", v, 8'hC0);
        peek(3'd0, v); chk("R1 baud", v, 0);
        peek(3'd1, v); chk("R1 ctl1", v, 0);
        peek(3'd2, v); chk("R1 ctl2", v, 0);
        chk("R1 irq", irq, 0);

        // R2 map and unused addresses
        wrt(3'd0, 8'h35); rdt(3'd0, v); chk("R2 baud readback", v, 8'h35);
        wrt(3'd1, 8'h10); rdt(3'd1, v); chk("R2 ctl1 readback", v, 8'h10);
        for (int a = 5; a < 8; a++) begin
            rdt(3'(a), v); chk("R2 unused addr", v, 0);
        end
        peek(3'd3, v); chk("R2 no side effect", v, 8'hC0);

        // R5 status write has no effect
        wrt(3'd3, 8'h00); peek(3'd3, v); chk("R5 status write 00", v, 8'hC0);
        wrt(3'd3, 8'hFF); peek(3'd3, v); chk("R5 status write FF", v, 8'hC0);

        // R10 interrupt enables
        wrt(3'd2, 8'h80); chk("R10 TIE irq", irq, 1);
        wrt(3'd2, 8'h40); chk("R10 TCIE irq", irq, 1);
        wrt(3'd2, 8'h10); chk("R10 ILIE no idle", irq, 0);
        wrt(3'd2, 8'h20); chk("R10 RIE no rx", irq, 0);

        // R7 with enable clear: byte waits, flags stay set
        wrt(3'd0, 8'h00); wrt(3'd1, 8'h00); wrt(3'd2, 8'h00);
        wrt(3'd4, 8'hA7); tick(15);
        peek(3'd3, v); chk("R7 held without enable", v, 8'hC0);
        chk("R7 no strobe without enable", tx_valid, 0);
        wrt(3'd2, 8'h08);
        c = 0;
        while (!tx_valid && c < 100) begin tick(1); c++; end
        chk("R7 held byte sent", tx_byte, 8'hA7);
        chk("R7 held byte time", c, 11);

        // R7 R8 sweep of baud and frame settings
        for (int sp = 0; sp < 4; sp++)
            for (int s = 0; s < 4; s++)
                for (int m = 0; m < 2; m++) begin
                    logic [7:0] b;
                    b = 8'((sp * 8 + s * 2 + m) ^ 8'h5A);
                    exp_n = (sp == 0 ? 1 : sp == 1 ? 3 : sp == 2 ? 4 : 13) * (1 << s) * (m ? 11 : 10);
                    wrt(3'd0, 8'((sp << 4) | s));
                    wrt(3'd1, m ? 8'h10 : 8'h00);
                    wrt(3'd4, b);
                    tick(1); c = 1;
                    peek(3'd3, v); chk("R7 launch clears flags", v, 8'h00);
                    while (!tx_valid && c < 3000) begin tick(1); c++; end
                    chk("R8 character time", c, exp_n + 1);
                    chk("R7 sent byte", tx_byte, b);
                    peek(3'd3, v); chk("R7 flags back", v, 8'hC0);
                end

        // R6 data write refused while transmit-empty clear
        wrt(3'd0, 8'h00); wrt(3'd1, 8'h00);
        wrt(3'd4, 8'h11); tick(1);
        wrt(3'd4, 8'h99);
        c = 2;
        while (!tx_valid && c < 100) begin tick(1); c++; end
        chk("R6 first byte kept", tx_byte, 8'h11);
        c = 0;
        for (int i = 0; i < 30; i++) begin tick(1); if (tx_valid) c++; end
        chk("R6 refused byte not sent", c, 0);

        // R9 R3 R4 R10 receive path, character time 10
        wrt(3'd2, 8'h24);
        rx_pulse(8'h3C);
        tick(9);
        peek(3'd3, v); chk("R9 before tick", v, 8'hC0);
        tick(1);
        peek(3'd3, v); chk("R9 delivered at tick", v, 8'hE0);
        chk("R10 RIE irq", irq, 1);
        rdt(3'd4, v); chk("R3 data value", v, 8'h3C);
        peek(3'd3, v); chk("R3 lone data read keeps flag", v, 8'hE0);
        rdt(3'd3, v); chk("R3 status read", v, 8'hE0);
        rx_pulse(8'hC5);
        tick(6);
        rdt(3'd4, v); chk("R4 old data on collision", v, 8'h3C);
        peek(3'd3, v); chk("R4 overrun on collision", v, 8'hE8);
        rdt(3'd3, v); chk("R4 status shows overrun", v, 8'hE8);
        rdt(3'd4, v); chk("R4 new data", v, 8'hC5);
        peek(3'd3, v); chk("R3 clear sequence", v, 8'hC0);
        chk("R10 irq drops", irq, 0);

        // R9 reception disabled
        wrt(3'd2, 8'h00);
        rx_pulse(8'h77);
        tick(40);
        peek(3'd3, v); chk("R9 disabled ignores byte", v, 8'hC0);
        wrt(3'd2, 8'h04);
        tick(30);
        peek(3'd3, v); chk("R9 byte lost while disabled", v, 8'hC0);

        // R1 bootstrap reset
        rst_n = 1'b0; boot_mode = 1'b1;
        tick(2);
        rst_n = 1'b1;
        peek(3'd2, v); chk("R1 bootstrap ctl2", v, 8'h12);
        peek(3'd3, v); chk("R1 bootstrap status", v, 8'hC0);
        chk("R1 bootstrap irq", irq, 0);

        summary();
    end
endmodule